// File: doc/BRIEF.md
# Paged Host Address Window Translator

This block sits behind an external host port and turns each 21-bit host address into a 28-bit address for the chip's internal fabric. The two top host address bits pick one of four 512 KB pages. Each page owns a 9-bit base value that becomes the upper part of the internal address, and the low 19 host bits pass through unchanged. Software programs each page's base, together with a per-page word-combine enable, through a simple register-write port.

The smallest window is special. It covers host addresses whose bits [20:13] are all zero, and it always translates with a zero base, whatever page 0 holds. Accesses there are flagged as aimed at the local register and peripheral region. Every other access is flagged as a memory-bus access. Alongside the address, the block decodes the two byte enables into an access size and a byte lane. It also raises a flag when neither enable is active.

A request is presented with a valid strobe. The translated result is registered on that strobe and held until the next strobe arrives.

Top module: `hpw_window_xlat`

## Requirements
- R1: After a synchronous active-low reset, every page base and word-combine bit is zero, `out_valid` is 0 and all result outputs are 0.
- R2: For an access outside the low window, `out_addr` equals {base of page `req_addr[20:19]`, `req_addr[18:0]`}. Bits [18:0] always equal `req_addr[18:0]`.
- R3: When `req_addr[20:13]` is all zero, the base used is zero even if page 0 holds a non-zero base, so `out_addr[27:13]` is zero and `out_is_reg` is 1.
- R4: When `req_addr[20:19]` is 00 and `req_addr[18:13]` is non-zero, page 0's base is used and `out_is_reg` is 0.
- R5: `out_wc` reports the word-combine bit of the selected page. Inside the low window it reports 0.
- R6: Byte enables map as follows. 2'b11 gives `out_half`=1 and `out_lane`=0. 2'b01 gives a byte on lane 0. 2'b10 gives a byte on lane 1 (`out_lane`=1). 2'b00 gives `out_bad`=1 with `out_half`=0 and `out_lane`=0.
- R7: Results appear on the clock edge that samples `req_valid`=1, with `out_valid` high for that one cycle. When `req_valid` is 0, `out_valid` goes low and the other outputs hold their values.
- R8: A register write takes effect on the next clock edge. A translation in the same cycle as a write to its page uses the old base.
- R9: A write changes only the page named by `cfg_page`. The other pages keep their base and word-combine bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Page register write strobe |
| cfg_page | input | 2 | Page index for the write |
| cfg_base | input | 9 | Base value to write |
| cfg_wc | input | 1 | Word-combine enable to write |
| req_valid | input | 1 | Host address valid strobe |
| req_addr | input | 21 | Host address |
| req_ben | input | 2 | Host byte enables, bit 0 = lane 0 |
| out_valid | output | 1 | Result registered this cycle |
| out_addr | output | 28 | Internal address |
| out_is_reg | output | 1 | 1 = register/peripheral region, 0 = memory bus |
| out_wc | output | 1 | Word-combine enable of the access |
| out_half | output | 1 | Halfword access |
| out_lane | output | 1 | Byte lane of a byte access |
| out_bad | output | 1 | No byte enable active |

## Verification
A register write and an address translation can fall in the same cycle, and they can target the same page. The bench provokes this by raising `cfg_we` for page 1 and `req_valid` with a page-1 address on the same falling edge. It then expects the result built from the old base, followed by the new base on the next request. It also writes page 0 with a non-zero base and translates a low-window address. This confirms that the zero-base bypass, rather than the register, wins.

// File: rtl/hpw_pkg.sv
// Package hpw_pkg
// Shared defaults and the internal size code for the host window translator.
// Assumes a two-bit byte-enable bus (halfword host port).
package hpw_pkg;

    localparam int unsigned HOST_AW_DEF   = 21;
    localparam int unsigned PAGE_BITS_DEF = 2;
    localparam int unsigned BASE_W_DEF    = 9;
    localparam int unsigned REG_WIN_DEF   = 13;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_HALF = 2'd2
    } hpw_size_e;

endpackage

// File: rtl/hpw_page_regs.sv
// Module hpw_page_regs
// Holds one base value and one word-combine bit per page.
// Assumes writes are single-cycle strobes; a write lands on the next edge.
module hpw_page_regs #(
    parameter int unsigned PAGE_BITS = hpw_pkg::PAGE_BITS_DEF,
    parameter int unsigned BASE_W    = hpw_pkg::BASE_W_DEF,
    localparam int unsigned NUM_PAGES = 1 << PAGE_BITS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [PAGE_BITS-1:0]        wr_page,
    input  logic [BASE_W-1:0]           wr_base,
    input  logic                        wr_wc,
    output logic [NUM_PAGES*BASE_W-1:0] base_flat,
    output logic [NUM_PAGES-1:0]        wc_vec
);

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
        logic [BASE_W-1:0] base_q;
        logic              wc_q;

        // Page storage: cleared by reset, loaded when this page is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                wc_q   <= 1'b0;
            end else if (wr_en && (wr_page == PAGE_BITS'(g))) begin
                base_q <= wr_base;
                wc_q   <= wr_wc;
            end
        end

        assign base_flat[g*BASE_W +: BASE_W] = base_q;
        assign wc_vec[g]                     = wc_q;
    end

endmodule

// File: rtl/hpw_addr_compose.sv
// Module hpw_addr_compose
// Combinational address composition: selects a page base from the top host
// bits, forces a zero base inside the low register window, and concatenates
// the in-page offset. Assumes REG_WIN < HOST_AW - PAGE_BITS.
module hpw_addr_compose #(
    parameter int unsigned HOST_AW   = hpw_pkg::HOST_AW_DEF,
    parameter int unsigned PAGE_BITS = hpw_pkg::PAGE_BITS_DEF,
    parameter int unsigned BASE_W    = hpw_pkg::BASE_W_DEF,
    parameter int unsigned REG_WIN   = hpw_pkg::REG_WIN_DEF,
    localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
    localparam int unsigned OFFSET_W  = HOST_AW - PAGE_BITS,
    localparam int unsigned INT_AW    = BASE_W + OFFSET_W
) (
    input  logic [HOST_AW-1:0]          host_addr,
    input  logic [NUM_PAGES*BASE_W-1:0] base_flat,
    input  logic [NUM_PAGES-1:0]        wc_vec,
    output logic [INT_AW-1:0]           int_addr,
    output logic                        is_reg,
    output logic                        wc_en
);

    logic [PAGE_BITS-1:0] page_sel;
    logic [BASE_W-1:0]    page_base;
    logic                 page_wc;
    logic                 low_win;

    // Page selection from the top host bits.
    always_comb begin
        page_sel  = host_addr[HOST_AW-1 -: PAGE_BITS];
        page_base = '0;
        page_wc   = 1'b0;
        for (int p = 0; p < NUM_PAGES; p++) begin
            if (page_sel == PAGE_BITS'(p)) begin
                page_base = base_flat[p*BASE_W +: BASE_W];
                page_wc   = wc_vec[p];
            end
        end
    end

    // Low-window detect and final composition with the zero-base bypass.
    always_comb begin
        low_win  = (host_addr[HOST_AW-1:REG_WIN] == '0);
        is_reg   = low_win;
        wc_en    = low_win ? 1'b0 : page_wc;
        int_addr = {(low_win ? {BASE_W{1'b0}} : page_base), host_addr[OFFSET_W-1:0]};
    end

endmodule

// File: rtl/hpw_size_decode.sv
// Module hpw_size_decode
// Maps the two host byte enables to a size code and a byte lane.
// Assumes enable bit 0 guards lane 0 and bit 1 guards lane 1.
module hpw_size_decode (
    input  logic             [1:0] ben,
    output hpw_pkg::hpw_size_e     size,
    output logic                   lane
);

    // Size and lane decode from the enable pattern.
    always_comb begin
        unique case (ben)
            2'b11:   begin size = hpw_pkg::SZ_HALF; lane = 1'b0; end
            2'b01:   begin size = hpw_pkg::SZ_BYTE; lane = 1'b0; end
            2'b10:   begin size = hpw_pkg::SZ_BYTE; lane = 1'b1; end
            default: begin size = hpw_pkg::SZ_NONE; lane = 1'b0; end
        endcase
    end

endmodule

// File: rtl/hpw_window_xlat.sv
// Module hpw_window_xlat
// Top of the paged host address window translator. Translation is
// combinational from the request inputs; results are registered on the
// request strobe and held between strobes. Assumes page writes and requests
// are synchronous to clk.
module hpw_window_xlat #(
    parameter int unsigned HOST_AW   = hpw_pkg::HOST_AW_DEF,
    parameter int unsigned PAGE_BITS = hpw_pkg::PAGE_BITS_DEF,
    parameter int unsigned BASE_W    = hpw_pkg::BASE_W_DEF,
    parameter int unsigned REG_WIN   = hpw_pkg::REG_WIN_DEF,
    localparam int unsigned NUM_PAGES = 1 << PAGE_BITS,
    localparam int unsigned OFFSET_W  = HOST_AW - PAGE_BITS,
    localparam int unsigned INT_AW    = BASE_W + OFFSET_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [PAGE_BITS-1:0] cfg_page,
    input  logic [BASE_W-1:0]    cfg_base,
    input  logic                 cfg_wc,
    input  logic                 req_valid,
    input  logic [HOST_AW-1:0]   req_addr,
    input  logic [1:0]           req_ben,
    output logic                 out_valid,
    output logic [INT_AW-1:0]    out_addr,
    output logic                 out_is_reg,
    output logic                 out_wc,
    output logic                 out_half,
    output logic                 out_lane,
    output logic                 out_bad
);

    logic [NUM_PAGES*BASE_W-1:0] base_flat;
    logic [NUM_PAGES-1:0]        wc_vec;
    logic [INT_AW-1:0]           xl_addr;
    logic                        xl_is_reg;
    logic                        xl_wc;
    hpw_pkg::hpw_size_e          xl_size;
    logic                        xl_lane;

    hpw_page_regs #(
        .PAGE_BITS (PAGE_BITS),
        .BASE_W    (BASE_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_page   (cfg_page),
        .wr_base   (cfg_base),
        .wr_wc     (cfg_wc),
        .base_flat (base_flat),
        .wc_vec    (wc_vec)
    );

    hpw_addr_compose #(
        .HOST_AW   (HOST_AW),
        .PAGE_BITS (PAGE_BITS),
        .BASE_W    (BASE_W),
        .REG_WIN   (REG_WIN)
    ) comp_i (
        .host_addr (req_addr),
        .base_flat (base_flat),
        .wc_vec    (wc_vec),
        .int_addr  (xl_addr),
        .is_reg    (xl_is_reg),
        .wc_en     (xl_wc)
    );

    hpw_size_decode size_i (
        .ben  (req_ben),
        .size (xl_size),
        .lane (xl_lane)
    );

    // Output strobe: follows the request strobe by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= req_valid;
    end

    // Result capture: loaded on a request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_is_reg <= 1'b0;
            out_wc     <= 1'b0;
            out_half   <= 1'b0;
            out_lane   <= 1'b0;
            out_bad    <= 1'b0;
        end else if (req_valid) begin
            out_addr   <= xl_addr;
            out_is_reg <= xl_is_reg;
            out_wc     <= xl_wc;
            out_half   <= (xl_size == hpw_pkg::SZ_HALF);
            out_lane   <= xl_lane;
            out_bad    <= (xl_size == hpw_pkg::SZ_NONE);
        end
    end

endmodule

// File: rtl/hpw_xlat_checker.sv
// Module hpw_xlat_checker
// Port-level temporal checks for hpw_window_xlat, attached with bind.
module hpw_xlat_checker #(
    parameter int unsigned HOST_AW   = 21,
    parameter int unsigned PAGE_BITS = 2,
    parameter int unsigned BASE_W    = 9,
    parameter int unsigned REG_WIN   = 13,
    localparam int unsigned OFFSET_W = HOST_AW - PAGE_BITS,
    localparam int unsigned INT_AW   = BASE_W + OFFSET_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [HOST_AW-1:0] req_addr,
    input logic [1:0]         req_ben,
    input logic               out_valid,
    input logic [INT_AW-1:0]  out_addr,
    input logic               out_is_reg,
    input logic               out_wc,
    input logic               out_half,
    input logic               out_bad
);

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && $stable(out_addr)));

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_addr[OFFSET_W-1:0] == $past(req_addr[OFFSET_W-1:0])));

    assert_low_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[HOST_AW-1:REG_WIN] == '0))
        |=> (out_is_reg && (out_addr[INT_AW-1:REG_WIN] == '0)));

    assert_mem_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[HOST_AW-1:REG_WIN] != '0)) |=> !out_is_reg);

    assert_no_wc_in_regs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_reg) |-> !out_wc);

    assert_size_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_half, out_bad}) <= 1));

    assert_no_enable_bad_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_ben == 2'b00)) |=> out_bad);

endmodule

bind hpw_window_xlat hpw_xlat_checker #(
    .HOST_AW   (HOST_AW),
    .PAGE_BITS (PAGE_BITS),
    .BASE_W    (BASE_W),
    .REG_WIN   (REG_WIN)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_ben    (req_ben),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_is_reg (out_is_reg),
    .out_wc     (out_wc),
    .out_half   (out_half),
    .out_bad    (out_bad)
);

// File: tb/hpw_window_xlat_tb_top.sv
// Bench for hpw_window_xlat: a vector table walked by one loop, then
// directed tests for reset, collisions and holds.
module hpw_window_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_page;
    logic [8:0]  cfg_base;
    logic        cfg_wc;
    logic        req_valid;
    logic [20:0] req_addr;
    logic [1:0]  req_ben;
    logic        out_valid;
    logic [27:0] out_addr;
    logic        out_is_reg, out_wc, out_half, out_lane, out_bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench copy of what has been programmed.
    logic [8:0] m_base [4];
    logic       m_wc   [4];

    always #4 clk = ~clk;

    hpw_window_xlat dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_page (cfg_page), .cfg_base (cfg_base), .cfg_wc (cfg_wc),
        .req_valid (req_valid), .req_addr (req_addr), .req_ben (req_ben),
        .out_valid (out_valid), .out_addr (out_addr), .out_is_reg (out_is_reg),
        .out_wc (out_wc), .out_half (out_half), .out_lane (out_lane), .out_bad (out_bad)
    );

    typedef struct packed {
        logic [20:0] addr;
        logic [1:0]  ben;
        logic        is_reg;
        logic        half;
        logic        lane;
        logic        bad;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{21'h000000, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0},
        '{21'h001FFF, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0},
        '{21'h002000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
        '{21'h07FFFF, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1},
        '{21'h080000, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
        '{21'h0ABCDE, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        '{21'h100000, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0},
        '{21'h1FFFFF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
        '{21'h180000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0},
        '{21'h040000, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0}
    };

    function automatic logic [27:0] exp_addr(input logic [20:0] a);
        logic [8:0] b;
        b = (a[20:13] == 8'd0) ? 9'd0 : m_base[a[20:19]];
        return {b, a[18:0]};
    endfunction

    function automatic logic exp_wc(input logic [20:0] a);
        return (a[20:13] == 8'd0) ? 1'b0 : m_wc[a[20:19]];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_page(input logic [1:0] p, input logic [8:0] b, input logic w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = p; cfg_base = b; cfg_wc = w;
        @(negedge clk);
        cfg_we = 1'b0;
        m_base[p] = b; m_wc[p] = w;
    endtask

    // Drive one request; on return the registered result is visible.
    task automatic request(input logic [20:0] a, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_ben = be;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_full(input string req, input logic [20:0] a);
        check(req, "out_valid", 32'(out_valid), 32'd1);
        check(req, "out_addr",  32'(out_addr),  32'(exp_addr(a)));
        check(req, "out_wc",    32'(out_wc),    32'(exp_wc(a)));
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_page = '0; cfg_base = '0; cfg_wc = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_ben = '0;
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_wc[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of outputs and of the page registers
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "out_addr",  32'(out_addr),  32'd0);
        check("R1", "flags", 32'({out_is_reg, out_wc, out_half, out_lane, out_bad}), 32'd0);
        request(21'h1ABCDE, 2'b11);
        check("R1", "page3 base after reset", 32'(out_addr), 32'h002BCDE);
        check("R1", "page3 wc after reset",   32'(out_wc),   32'd0);

        // Program pages; page 0 non-zero to exercise the bypass (R3)
        write_page(2'd0, 9'h0A5, 1'b1);
        write_page(2'd1, 9'h123, 1'b0);
        write_page(2'd2, 9'h1FF, 1'b1);
        write_page(2'd3, 9'h001, 1'b1);

        // Table walk: R2, R3, R4, R5, R6
        for (int i = 0; i < NVEC; i++) begin
            request(VECS[i].addr, VECS[i].ben);
            check_full("R2", VECS[i].addr);
            check(VECS[i].is_reg ? "R3" : "R4", "out_is_reg", 32'(out_is_reg), 32'(VECS[i].is_reg));
            check("R6", "out_half", 32'(out_half), 32'(VECS[i].half));
            check("R6", "out_lane", 32'(out_lane), 32'(VECS[i].lane));
            check("R6", "out_bad",  32'(out_bad),  32'(VECS[i].bad));
        end

        // R3: low window top edge ignores page 0 base explicitly
        request(21'h001234, 2'b11);
        check("R3", "bypass", 32'(out_addr), 32'h0001234);
        // R4: first address above low window uses page 0 base
        request(21'h002000, 2'b11);
        check("R4", "page0 used", 32'(out_addr), {4'h0, 9'h0A5, 19'h02000});
        // R5: page 0 wc=1 shows outside the window only
        check("R5", "page0 wc", 32'(out_wc), 32'd1);

        // R7: hold with req_valid low while the address changes
        @(negedge clk);
        req_addr = 21'h155555; req_ben = 2'b00;
        @(negedge clk);
        check("R7", "valid drops", 32'(out_valid), 32'd0);
        check("R7", "addr held",   32'(out_addr),  {4'h0, 9'h0A5, 19'h02000});
        check("R7", "half held",   32'(out_half),  32'd1);

        // R8: write and translate page 1 in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = 2'd1; cfg_base = 9'h0F0; cfg_wc = 1'b1;
        req_valid = 1'b1; req_addr = 21'h0A0001; req_ben = 2'b11;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R8", "old base used", 32'(out_addr), {4'h0, 9'h123, 19'h20001});
        check("R8", "old wc used",   32'(out_wc),   32'd0);
        m_base[1] = 9'h0F0; m_wc[1] = 1'b1;
        request(21'h0A0001, 2'b11);
        check("R8", "new base used", 32'(out_addr), {4'h0, 9'h0F0, 19'h20001});
        check("R8", "new wc used",   32'(out_wc),   32'd1);

        // R9: other pages untouched by the page 1 write
        request(21'h100010, 2'b01);
        check_full("R9", 21'h100010);
        request(21'h180010, 2'b01);
        check_full("R9", 21'h180010);

        // R1: mid-run reset clears the pages
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_wc[i] = 1'b0; end
        request(21'h0C0000, 2'b11);
        check("R1", "page1 cleared", 32'(out_addr), 32'h0040000);
        check("R1", "page1 wc cleared", 32'(out_wc), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule